// File: doc/BRIEF.md
# External Interrupt Input Controller

This block sits between two external interrupt request pins and a CPU. Each pin has its own 16-bit control register, which software programs over a simple register bus. The register selects how the pin raises a request (a latched rising edge or a live high level), whether the source is masked, and a 3-bit priority. Both pins pass through a synchronizer before they are used. Rising edges are caught in a one-deep latch that holds until software acknowledges that source. Level requests follow the synchronized pin directly.

Among the unmasked pending sources, the block picks a single winner. It presents one request line and the winner's source ID to the CPU. The CPU answers with a one-cycle acknowledge that carries the serviced ID, and this clears that source's edge latch. Source ID 0 is the first pin, whose register sits at 3Ch. Source ID 1 is the second pin, whose register sits at 3Eh.

Top module: `ext_irq_ctl`

## Requirements
- R1: After reset, both control registers read 000Fh (masked, priority 7, no trigger mode) and irqReq is low.
- R2: The control register for source ID 0 is at address 3Ch and the one for source ID 1 is at address 3Eh. A read of any other address returns 0, and a write to any other address changes neither register.
- R3: Control register fields: bit 7 enables edge triggering, bit 4 selects level mode, bit 3 masks the source, and bits 2:0 hold the priority. Bits 15:8, 6 and 5 always read 0, whatever was written to them.
- R4: While bit 3 is 1, the source raises no request. An edge latched while the source is masked is kept, and it raises the request as soon as bit 3 is cleared.
- R5: With bit 4 = 1 (bit 7 is then ignored), the source is pending exactly while its synchronized pin is high. An acknowledge has no effect on it.
- R6: With bit 7 = 1 and bit 4 = 0, a rising edge on the pin sets the source pending. The source stays pending after the pin falls. Further edges while it is pending are not counted, so one acknowledge clears it.
- R7: An acknowledge (ackValid high for one cycle) clears only the edge latch of the source named by ackId. An acknowledge naming the other source leaves this one pending.
- R8: With bits 7 and 4 both 0, the source raises no request and rising edges are not latched. An edge already latched is kept, and it raises the request again when edge mode is re-enabled.
- R9: When several unmasked sources are pending, irqId names the one with the lowest priority value. On equal priority, source ID 0 wins.
- R10: Pin inputs pass through a two-stage synchronizer. In level mode, a pin that rises between two clock edges shows on irqReq after the second following edge and not after the first. In edge mode it shows after the third following edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | ADDR_W (8) | Register bus address |
| regWe | input | 1 | Register write enable |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data, combinational from regAddr |
| irqPin | input | 2 | External interrupt pins, index = source ID |
| irqReq | output | 1 | Interrupt request to the CPU |
| irqId | output | 1 | Source ID of the winning request |
| ackValid | input | 1 | One-cycle acknowledge strobe |
| ackId | input | 1 | Source ID being acknowledged |

## Verification
The bench builds the block with its default parameters: two sources, 3-bit priorities, an 8-bit address with registers at 3Ch and 3Eh, and a two-stage synchronizer. With these values, both source IDs and the tie-break between them can be reached directly. The full register width can be exercised, including the reserved bits. The synchronizer depth is short enough that the exact cycle on which a request first appears can be pinned down for both level and edge modes.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned NUM_SRC   = 2;
  localparam int unsigned PRIO_W    = 3;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned ID_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  // Bit positions that software decodes
  localparam int unsigned EDGE_BIT  = 7;
  localparam int unsigned LEVEL_BIT = 4;
  localparam int unsigned MASK_BIT  = 3;

  typedef struct packed {
    logic              edgeEn;
    logic              levelMode;
    logic              mask;
    logic [PRIO_W-1:0] prio;
  } src_cfg_t;

  localparam src_cfg_t CFG_RESET = '{edgeEn: 1'b0, levelMode: 1'b0,
                                     mask: 1'b1, prio: {PRIO_W{1'b1}}};

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_SRC-1:0] wrSel;
    logic [NUM_SRC-1:0] rdSel;
    logic [NUM_SRC-1:0] ackClr;
  } strobe_t;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned          ADDR_W      = 8,
  parameter logic [ADDR_W-1:0]    BASE_ADDR   = 8'h3C,
  parameter int unsigned          ADDR_STRIDE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic              ackValid,
  input  logic [ID_W-1:0]   ackId,
  output strobe_t           strb
);
  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_dec
    localparam logic [ADDR_W-1:0] MY_ADDR = BASE_ADDR + ADDR_W'(g * ADDR_STRIDE);
    assign hit[g]         = (regAddr == MY_ADDR);
    assign strb.ackClr[g] = ackValid && (ackId == ID_W'(g));
  end

  assign strb.rdSel = hit;
  assign strb.wrSel = hit & {NUM_SRC{regWe}};

  // R2: at most one register selected per access
  a_r2_single_select: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.wrSel) && $onehot0(strb.ackClr));
endmodule

// File: rtl/ext_irq_dp.sv
module ext_irq_dp
  import ext_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic [NUM_SRC-1:0] pinSync,
  output logic [DATA_W-1:0]  regRdata,
  output logic               irqReq,
  output logic [ID_W-1:0]    irqId
);
  src_cfg_t [NUM_SRC-1:0] cfgQ;
  logic [NUM_SRC-1:0] prevLvl, edgeLatch, riseHit, armEdge, pending, reqVec;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      riseHit[i] = pinSync[i] & ~prevLvl[i];
      armEdge[i] = cfgQ[i].edgeEn & ~cfgQ[i].levelMode;
      pending[i] = cfgQ[i].levelMode ? pinSync[i] : (cfgQ[i].edgeEn & edgeLatch[i]);
      reqVec[i]  = pending[i] & ~cfgQ[i].mask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) cfgQ[i] <= CFG_RESET;
      prevLvl   <= '0;
      edgeLatch <= '0;
    end else begin
      prevLvl <= pinSync;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (strb.wrSel[i]) begin
          cfgQ[i].edgeEn    <= regWdata[EDGE_BIT];
          cfgQ[i].levelMode <= regWdata[LEVEL_BIT];
          cfgQ[i].mask      <= regWdata[MASK_BIT];
          cfgQ[i].prio      <= regWdata[PRIO_W-1:0];
        end
        if (armEdge[i] && riseHit[i])  edgeLatch[i] <= 1'b1;
        else if (strb.ackClr[i])       edgeLatch[i] <= 1'b0;
      end
    end
  end

  // Read mux: reserved bits stay zero
  always_comb begin
    regRdata = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (strb.rdSel[i]) begin
        regRdata[EDGE_BIT]     = cfgQ[i].edgeEn;
        regRdata[LEVEL_BIT]    = cfgQ[i].levelMode;
        regRdata[MASK_BIT]     = cfgQ[i].mask;
        regRdata[PRIO_W-1:0]   = cfgQ[i].prio;
      end
    end
  end

  // Arbiter: lowest prio value, strict compare keeps lower index on tie
  logic [PRIO_W-1:0] bestPrio;
  always_comb begin
    irqReq   = 1'b0;
    irqId    = '0;
    bestPrio = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (reqVec[i] && (!irqReq || cfgQ[i].prio < bestPrio)) begin
        irqReq   = 1'b1;
        irqId    = ID_W'(i);
        bestPrio = cfgQ[i].prio;
      end
    end
  end

  // R9: the granted source never loses to another requester
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      if (rstN && irqReq && reqVec[i]) begin
        a_r9_best_prio: assert (cfgQ[irqId].prio <= cfgQ[i].prio);
      end
    end
  end

  // R4: a masked source is never granted
  a_r4_mask_blocks: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> !cfgQ[irqId].mask);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
    // R6: a latched edge survives until its acknowledge
    a_r6_edge_hold: assert property (@(posedge clk) disable iff (!rstN)
      edgeLatch[g] && !strb.ackClr[g] |=> edgeLatch[g]);
    // R7: acknowledge without a fresh edge empties the latch
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
      strb.ackClr[g] && !(armEdge[g] && riseHit[g]) |=> !edgeLatch[g]);
    // R8: no latching outside edge mode
    a_r8_no_latch_off: assert property (@(posedge clk) disable iff (!rstN)
      !edgeLatch[g] && !armEdge[g] |=> !edgeLatch[g]);
  end
endmodule

// File: rtl/ext_irq_ctl.sv
module ext_irq_ctl
  import ext_irq_pkg::*;
#(
  parameter int unsigned          ADDR_W      = 8,
  parameter logic [ADDR_W-1:0]    BASE_ADDR   = 8'h3C,
  parameter int unsigned          ADDR_STRIDE = 2,
  parameter int unsigned          SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWe,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic [NUM_SRC-1:0] irqPin,
  output logic               irqReq,
  output logic [ID_W-1:0]    irqId,
  input  logic               ackValid,
  input  logic [ID_W-1:0]    ackId
);
  strobe_t            strb;
  logic [NUM_SRC-1:0] pinSync;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
    ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rstN(rstN), .din(irqPin[g]), .dout(pinSync[g]));
  end

  ext_irq_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .ADDR_STRIDE(ADDR_STRIDE)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .ackValid(ackValid), .ackId(ackId), .strb(strb));

  ext_irq_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWdata(regWdata), .pinSync(pinSync),
    .regRdata(regRdata), .irqReq(irqReq), .irqId(irqId));
endmodule

// File: tb/sim_ext_irq_ctl.sv
module sim_ext_irq_ctl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic [1:0]  irqPin = '0;
  logic        irqReq;
  logic [0:0]  irqId;
  logic        ackValid = 1'b0;
  logic [0:0]  ackId = '0;

  int totalCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  ext_irq_ctl u0 (.clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .irqPin(irqPin), .irqReq(irqReq),
    .irqId(irqId), .ackValid(ackValid), .ackId(ackId));

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    totalCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; irqPin = '0; regWe = 1'b0; ackValid = 1'b0;
    tick(2);
    rstN = 1'b1;
    tick(1);
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [15:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    tick(1);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [15:0] d);
    regAddr = a; #1; d = regRdata;
  endtask

  task automatic ack(input logic [0:0] id);
    ackId = id; ackValid = 1'b1;
    tick(1);
    ackValid = 1'b0;
  endtask

  task automatic chkReq(input string tag, input logic expReq, input logic [0:0] expId);
    chk(irqReq === expReq && (!expReq || irqId === expId), tag,
        {14'd0, irqId, irqReq}, {14'd0, expId, expReq});
  endtask

  task automatic testReset();
    logic [15:0] d;
    doReset();
    regRead(8'h3C, d); chk(d === 16'h000F, "R1 reg id0 reset", d, 16'h000F);
    regRead(8'h3E, d); chk(d === 16'h000F, "R1 reg id1 reset", d, 16'h000F);
    chkReq("R1 no request after reset", 1'b0, 1'b0);
  endtask

  task automatic testRegMap();
    logic [15:0] d;
    doReset();
    regWrite(8'h3C, 16'hFFFF);
    regRead(8'h3C, d); chk(d === 16'h009F, "R3 reserved bits read 0", d, 16'h009F);
    regWrite(8'h3E, 16'h0012);
    regRead(8'h3E, d); chk(d === 16'h0012, "R3 fields id1", d, 16'h0012);
    regWrite(8'h40, 16'h5555);
    regRead(8'h40, d); chk(d === 16'h0000, "R2 unmapped read 0", d, 16'h0000);
    regRead(8'h3C, d); chk(d === 16'h009F, "R2 unmapped write id0 kept", d, 16'h009F);
    regRead(8'h3E, d); chk(d === 16'h0012, "R2 unmapped write id1 kept", d, 16'h0012);
  endtask

  task automatic testLevel();
    doReset();
    regWrite(8'h3C, 16'h0090);  // level + edge bit, unmasked, prio 0
    irqPin[0] = 1'b1;
    tick(1); chkReq("R10 level not after one edge", 1'b0, 1'b0);
    tick(1); chkReq("R10 level after two edges", 1'b1, 1'b0);
    ack(1'b0);
    chkReq("R5 ack ignored in level mode", 1'b1, 1'b0);
    irqPin[0] = 1'b0;
    tick(2); chkReq("R5 level drops with pin", 1'b0, 1'b0);
  endtask

  task automatic testEdge();
    doReset();
    regWrite(8'h3C, 16'h0080);
    irqPin[0] = 1'b1;
    tick(2); chkReq("R10 edge not after two edges", 1'b0, 1'b0);
    tick(1); chkReq("R10 edge after three edges", 1'b1, 1'b0);
    irqPin[0] = 1'b0;
    tick(4); chkReq("R6 edge held after pin falls", 1'b1, 1'b0);
    for (int k = 0; k < 2; k++) begin
      irqPin[0] = 1'b1; tick(2); irqPin[0] = 1'b0; tick(3);
    end
    ack(1'b1);
    chkReq("R7 ack of other id ignored", 1'b1, 1'b0);
    ack(1'b0);
    chkReq("R7 ack clears latch", 1'b0, 1'b0);
    tick(3); chkReq("R6 extra edges not counted", 1'b0, 1'b0);
  endtask

  task automatic testMask();
    doReset();
    regWrite(8'h3C, 16'h0088);  // edge, masked
    irqPin[0] = 1'b1;
    tick(4); chkReq("R4 masked no request", 1'b0, 1'b0);
    regWrite(8'h3C, 16'h0080);
    chkReq("R4 latched edge shows on unmask", 1'b1, 1'b0);
  endtask

  task automatic testOff();
    doReset();
    regWrite(8'h3E, 16'h0000);
    irqPin[1] = 1'b1;
    tick(4); chkReq("R8 off mode pin high no request", 1'b0, 1'b0);
    regWrite(8'h3E, 16'h0080);
    tick(3); chkReq("R8 off mode edge not latched", 1'b0, 1'b0);
    irqPin[1] = 1'b0; tick(3);
    irqPin[1] = 1'b1; tick(4);
    chkReq("R6 id1 edge latched", 1'b1, 1'b1);
    regWrite(8'h3E, 16'h0000);
    chkReq("R8 off mode hides latch", 1'b0, 1'b0);
    regWrite(8'h3E, 16'h0080);
    chkReq("R8 latch kept through off mode", 1'b1, 1'b1);
  endtask

  task automatic testArb();
    doReset();
    regWrite(8'h3C, 16'h0015);
    regWrite(8'h3E, 16'h0012);
    irqPin = 2'b11;
    tick(3); chkReq("R9 lower prio value wins", 1'b1, 1'b1);
    regWrite(8'h3E, 16'h0015);
    chkReq("R9 tie goes to id0", 1'b1, 1'b0);
    regWrite(8'h3C, 16'h0017);
    chkReq("R9 id1 wins with lower value", 1'b1, 1'b1);
    regWrite(8'h3E, 16'h001D);
    chkReq("R4 masked id1 loses", 1'b1, 1'b0);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      totalCnt++; failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    testReset();
    testRegMap();
    testLevel();
    testEdge();
    testMask();
    testOff();
    testArb();
    done = 1'b1;
    finishRun();
  end
endmodule